// File: doc/BRIEF.md
# IP-to-MAC Routing Cache

This block is a shared address-resolution table for the transmit side of an IP stack. Several transmit clients each present a destination IP address and wait. A round-robin arbiter serves one lookup at a time. For each lookup the block compares the destination with the node's own address under the subnet mask. A destination on the local subnet is searched for directly. Any other destination is replaced by the gateway address, so the client receives the gateway's 48-bit MAC address. The result comes back as a one-cycle done pulse to the client that was served, with a found flag and the MAC address.

The table holds a parameterised number of records. Each record has a key, a MAC address and the tick count of its last write. Lookups and learns walk the records one per cycle. A lookup that misses raises a one-cycle query request carrying the searched address, and so does a lookup that hits a record older than the refresh period. An external query generator turns this request into a resolution packet. Replies come back on the learn port. A learn for an address already in the table rewrites that record in place. Otherwise the learn takes an empty record, or if there is none, the record with the oldest timestamp. Learns for off-subnet addresses are dropped.

Ages are measured in ticks of an external 100 ms strobe. A tick counter inside the block supplies the timestamps. Ages are computed modulo the counter width, so the counter may wrap.

Top module: `ip_mac_route_cache`

## Requirements
- R1: After reset, no done pulse and no query pulse are present and learn_ready is 1. The table is empty, so the first lookup of any address misses.
- R2: A lookup of an on-subnet address that is in the table returns found=1 and the stored MAC with its done pulse. No query pulse is raised.
- R3: A lookup that misses returns found=1'b0 and an all-zero MAC. In the same cycle as the done pulse it raises query_valid for one cycle, with query_ip set to the searched address. query_valid never appears without a done pulse.
- R4: A destination is on-subnet when ((dest XOR local_ip) AND subnet_mask) is zero. For any other destination the searched key is gateway_ip, so both a hit and a query use the gateway address.
- R5: A learned address that is off-subnet under the current mask is never written into the table.
- R6: A learn whose address is already in the table overwrites that record's MAC and timestamp. It allocates no new record and evicts nothing.
- R7: A learn for a new address writes the first empty record if one exists. Otherwise it writes the record with the largest age (now minus timestamp), and on a tie the lowest index wins.
- R8: A hit whose age is strictly greater than refresh_period still returns found=1 and the MAC, and also raises a query pulse. Age is computed modulo 2^TS_W, and an age equal to refresh_period is not stale.
- R9: Simultaneous requesters are served in rotating order, starting after the last one served. At most one done bit is high at a time. Each done pulse lasts one cycle and only goes to a requester that was asserting req_valid.
- R10: learn_ready falls in the cycle after a learn is accepted and stays low until that learn is resolved. A learn_valid offered while learn_ready is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle 100 ms strobe that advances the timestamp counter |
| local_ip | input | IP_W | Node's own IP address |
| subnet_mask | input | IP_W | Mask for the on-subnet test |
| gateway_ip | input | IP_W | Gateway address used for off-subnet destinations |
| refresh_period | input | TS_W | Maximum age in ticks before a record counts as stale |
| req_valid | input | N_REQ | Lookup request per client, held until its done pulse |
| req_ip | input | N_REQ*IP_W | Destination address per client; client k uses bits k*IP_W and up |
| rsp_done | output | N_REQ | One-cycle completion pulse per client |
| rsp_found | output | 1 | Record found, valid with a done pulse |
| rsp_mac | output | 48 | Resolved MAC address, zero on a miss |
| query_valid | output | 1 | One-cycle request for an address-resolution query |
| query_ip | output | IP_W | Address to resolve, valid with query_valid |
| learn_valid | input | 1 | New resolution result offered |
| learn_ip | input | IP_W | Address of the resolution result |
| learn_mac | input | 48 | MAC address of the resolution result |
| learn_ready | output | 1 | A learn offered in this cycle is taken |

## Verification
The bench builds the block with three requesters, eight records and an 8-bit timestamp. With eight records the table fills after a handful of learns, so eviction order, in-place rewrite and empty-slot preference can all be seen within a few dozen operations. The 8-bit counter wraps after 256 ticks, which lets the bench check age arithmetic across the wrap in a short run. Three requesters raised in the same cycle show the rotation order directly.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int MAC_W = 48;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } rc_state_e;
endpackage

// File: rtl/rc_rst_sync.sv
module rc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/rc_rr_arb.sv
module rc_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          any,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] last_d;

  // search starts one past the last served requester and wraps
  always_comb begin
    int c;
    any     = 1'b0;
    gnt_idx = '0;
    for (int k = 1; k <= N; k++) begin
      c = int'(last_q) + k;
      if (c >= N) c = c - N;
      if (!any && req[c]) begin
        any     = 1'b1;
        gnt_idx = IW'(c);
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (take) last_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end
endmodule

// File: rtl/rc_store.sv
module rc_store #(
  parameter int DEPTH = 128,
  parameter int KEY_W = 32,
  parameter int MAC_W = 48,
  parameter int TS_W  = 20,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [MAC_W-1:0] wr_mac,
  input  logic [TS_W-1:0]  wr_ts,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [KEY_W-1:0] rd_key,
  output logic [MAC_W-1:0] rd_mac,
  output logic [TS_W-1:0]  rd_ts
);
  logic             vld_a [DEPTH];
  logic [KEY_W-1:0] key_a [DEPTH];
  logic [MAC_W-1:0] mac_a [DEPTH];
  logic [TS_W-1:0]  ts_a  [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_rec
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_a[e] <= 1'b0;
      else if (sel) vld_a[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        key_a[e] <= wr_key;
        mac_a[e] <= wr_mac;
        ts_a[e]  <= wr_ts;
      end
    end
  end

  assign rd_valid = vld_a[rd_idx];
  assign rd_key   = key_a[rd_idx];
  assign rd_mac   = mac_a[rd_idx];
  assign rd_ts    = ts_a[rd_idx];
endmodule

// File: rtl/ip_mac_route_cache.sv
module ip_mac_route_cache
  import rc_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int DEPTH = 128,
  parameter int IP_W  = 32,
  parameter int TS_W  = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [IP_W-1:0]       local_ip,
  input  logic [IP_W-1:0]       subnet_mask,
  input  logic [IP_W-1:0]       gateway_ip,
  input  logic [TS_W-1:0]       refresh_period,
  input  logic [N_REQ-1:0]      req_valid,
  input  logic [N_REQ*IP_W-1:0] req_ip,
  output logic [N_REQ-1:0]      rsp_done,
  output logic                  rsp_found,
  output logic [MAC_W-1:0]      rsp_mac,
  output logic                  query_valid,
  output logic [IP_W-1:0]       query_ip,
  input  logic                  learn_valid,
  input  logic [IP_W-1:0]       learn_ip,
  input  logic [MAC_W-1:0]      learn_mac,
  output logic                  learn_ready
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int GID_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  function automatic logic on_subnet(input logic [IP_W-1:0] ip);
    return ((ip ^ local_ip) & subnet_mask) == '0;
  endfunction

  logic rst_sync_n;

  rc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // control and datapath state
  rc_state_e        state_q, state_d;
  logic             op_learn_q, op_learn_d;
  logic [IP_W-1:0]  target_q, target_d;
  logic [GID_W-1:0] gid_q, gid_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] best_idx_q, best_idx_d;
  logic [TS_W:0]    best_score_q, best_score_d;
  logic             pend_q, pend_d;
  logic [IP_W-1:0]  pend_ip_q, pend_ip_d;
  logic [MAC_W-1:0] pend_mac_q, pend_mac_d;
  logic [TS_W-1:0]  now_q, now_d;
  logic [N_REQ-1:0] done_q, done_d;
  logic             found_q, found_d;
  logic [MAC_W-1:0] mac_q, mac_d;
  logic             qv_q, qv_d;
  logic [IP_W-1:0]  qip_q, qip_d;

  // arbiter
  logic             arb_any;
  logic             arb_take;
  logic [GID_W-1:0] arb_idx;
  logic [IP_W-1:0]  gnt_ip;

  rc_rr_arb #(.N(N_REQ)) u_arb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req     (req_valid),
    .take    (arb_take),
    .any     (arb_any),
    .gnt_idx (arb_idx)
  );

  assign gnt_ip = req_ip[int'(arb_idx)*IP_W +: IP_W];

  // record store
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             rd_valid;
  logic [IP_W-1:0]  rd_key;
  logic [MAC_W-1:0] rd_mac;
  logic [TS_W-1:0]  rd_ts;

  rc_store #(
    .DEPTH (DEPTH),
    .KEY_W (IP_W),
    .MAC_W (MAC_W),
    .TS_W  (TS_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_key   (pend_ip_q),
    .wr_mac   (pend_mac_q),
    .wr_ts    (now_q),
    .rd_idx   (idx_q),
    .rd_valid (rd_valid),
    .rd_key   (rd_key),
    .rd_mac   (rd_mac),
    .rd_ts    (rd_ts)
  );

  // per-entry evaluation during the scan
  logic            hit;
  logic [TS_W-1:0] age;
  logic [TS_W:0]   score;
  logic            better;
  logic            scan_end;

  assign hit      = rd_valid && (rd_key == target_q);
  assign age      = now_q - rd_ts;
  assign score    = rd_valid ? {1'b0, age} : {1'b1, {TS_W{1'b0}}};
  assign better   = (idx_q == '0) || (score > best_score_q);
  assign scan_end = hit || (idx_q == LAST_IDX);

  always_comb begin
    state_d      = state_q;
    op_learn_d   = op_learn_q;
    target_d     = target_q;
    gid_d        = gid_q;
    idx_d        = idx_q;
    best_idx_d   = best_idx_q;
    best_score_d = best_score_q;
    pend_d       = pend_q;
    pend_ip_d    = pend_ip_q;
    pend_mac_d   = pend_mac_q;
    done_d       = '0;
    found_d      = found_q;
    mac_d        = mac_q;
    qv_d         = 1'b0;
    qip_d        = qip_q;
    arb_take     = 1'b0;
    wr_en        = 1'b0;
    wr_idx       = idx_q;
    now_d        = tick ? now_q + 1'b1 : now_q;

    if (learn_valid && !pend_q) begin
      pend_d     = 1'b1;
      pend_ip_d  = learn_ip;
      pend_mac_d = learn_mac;
    end

    case (state_q)
      ST_IDLE: begin
        if (pend_q) begin
          if (on_subnet(pend_ip_q)) begin
            op_learn_d = 1'b1;
            target_d   = pend_ip_q;
            idx_d      = '0;
            state_d    = ST_SCAN;
          end else begin
            pend_d = 1'b0;
          end
        end else if (arb_any) begin
          arb_take   = 1'b1;
          op_learn_d = 1'b0;
          gid_d      = arb_idx;
          target_d   = on_subnet(gnt_ip) ? gnt_ip : gateway_ip;
          idx_d      = '0;
          state_d    = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (scan_end) begin
          if (op_learn_q) begin
            wr_en  = 1'b1;
            wr_idx = (hit || better) ? idx_q : best_idx_q;
            pend_d = 1'b0;
          end else begin
            done_d[gid_q] = 1'b1;
            found_d       = hit;
            mac_d         = hit ? rd_mac : '0;
            qv_d          = !hit || (age > refresh_period);
            qip_d         = target_q;
          end
          state_d = ST_DONE;
        end else begin
          if (better) begin
            best_idx_d   = idx_q;
            best_score_d = score;
          end
          idx_d = idx_q + 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q      <= ST_IDLE;
      op_learn_q   <= 1'b0;
      target_q     <= '0;
      gid_q        <= '0;
      idx_q        <= '0;
      best_idx_q   <= '0;
      best_score_q <= '0;
      pend_q       <= 1'b0;
      pend_ip_q    <= '0;
      pend_mac_q   <= '0;
      now_q        <= '0;
      done_q       <= '0;
      found_q      <= 1'b0;
      mac_q        <= '0;
      qv_q         <= 1'b0;
      qip_q        <= '0;
    end else begin
      state_q      <= state_d;
      op_learn_q   <= op_learn_d;
      target_q     <= target_d;
      gid_q        <= gid_d;
      idx_q        <= idx_d;
      best_idx_q   <= best_idx_d;
      best_score_q <= best_score_d;
      pend_q       <= pend_d;
      pend_ip_q    <= pend_ip_d;
      pend_mac_q   <= pend_mac_d;
      now_q        <= now_d;
      done_q       <= done_d;
      found_q      <= found_d;
      mac_q        <= mac_d;
      qv_q         <= qv_d;
      qip_q        <= qip_d;
    end
  end

  assign rsp_done    = done_q;
  assign rsp_found   = found_q;
  assign rsp_mac     = mac_q;
  assign query_valid = qv_q;
  assign query_ip    = qip_q;
  assign learn_ready = !pend_q;
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int N_REQ = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] rsp_done,
  input logic [N_REQ-1:0] req_valid,
  input logic             rsp_found,
  input logic [47:0]      rsp_mac,
  input logic             query_valid,
  input logic             learn_valid,
  input logic             learn_ready
);
  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_done)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_done) |=> !(|rsp_done)); // R9
  AST_DONE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done & ~$past(req_valid)) == '0); // R9
  AST_QUERY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    query_valid |-> (|rsp_done)); // R3
  AST_MISS_QUERIES: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rsp_done) && !rsp_found) |-> (query_valid && rsp_mac == '0)); // R3
  AST_LEARN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (learn_valid && learn_ready) |=> !learn_ready); // R10
endmodule

bind ip_mac_route_cache rc_checker #(.N_REQ(N_REQ)) u_rc_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .rsp_done    (rsp_done),
  .req_valid   (req_valid),
  .rsp_found   (rsp_found),
  .rsp_mac     (rsp_mac),
  .query_valid (query_valid),
  .learn_valid (learn_valid),
  .learn_ready (learn_ready)
);

// File: tb/ip_mac_route_cache_bench.sv
`timescale 1ns/1ps
module ip_mac_route_cache_bench;
  localparam int NR = 3;
  localparam int DP = 8;
  localparam int IW = 32;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick;
  logic [IW-1:0] local_ip, subnet_mask, gateway_ip;
  logic [TW-1:0] refresh_period;
  logic [NR-1:0] req_valid;
  logic [NR*IW-1:0] req_ip;
  logic [NR-1:0] rsp_done;
  logic          rsp_found;
  logic [47:0]   rsp_mac;
  logic          query_valid;
  logic [IW-1:0] query_ip;
  logic          learn_valid;
  logic [IW-1:0] learn_ip;
  logic [47:0]   learn_mac;
  logic          learn_ready;

  always #2 clk = ~clk;

  ip_mac_route_cache #(.N_REQ(NR), .DEPTH(DP), .IP_W(IW), .TS_W(TW)) u_ip_mac_route_cache (
    .clk(clk), .rst_n(rst_n), .tick(tick), .local_ip(local_ip), .subnet_mask(subnet_mask),
    .gateway_ip(gateway_ip), .refresh_period(refresh_period), .req_valid(req_valid),
    .req_ip(req_ip), .rsp_done(rsp_done), .rsp_found(rsp_found), .rsp_mac(rsp_mac),
    .query_valid(query_valid), .query_ip(query_ip), .learn_valid(learn_valid),
    .learn_ip(learn_ip), .learn_mac(learn_mac), .learn_ready(learn_ready)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int now_cnt  = 0;

  typedef struct packed {
    logic        is_learn;
    logic [1:0]  rid;
    logic [31:0] ip;
    logic [47:0] mac;
    logic        exp_found;
    logic        exp_query;
    logic [31:0] exp_qip;
  } vec_t;

  // learn rows carry the MAC to store; lookup rows carry the expected MAC
  localparam vec_t VEC [10] = '{
    '{1'b0, 2'd0, 32'h0A000010, 48'h0,            1'b0, 1'b1, 32'h0A000010}, // R1 R3
    '{1'b1, 2'd0, 32'h0A000010, 48'h000011110010, 1'b0, 1'b0, 32'h0},
    '{1'b0, 2'd1, 32'h0A000010, 48'h000011110010, 1'b1, 1'b0, 32'h0},        // R2
    '{1'b0, 2'd2, 32'hC0A80101, 48'h0,            1'b0, 1'b1, 32'h0A000001}, // R4
    '{1'b1, 2'd0, 32'h0A000001, 48'h000022220001, 1'b0, 1'b0, 32'h0},
    '{1'b0, 2'd0, 32'hC0A80101, 48'h000022220001, 1'b1, 1'b0, 32'h0},        // R4
    '{1'b1, 2'd0, 32'h0A000020, 48'h000011110020, 1'b0, 1'b0, 32'h0},
    '{1'b0, 2'd1, 32'h0A000020, 48'h000011110020, 1'b1, 1'b0, 32'h0},        // R2
    '{1'b1, 2'd0, 32'hC0A80105, 48'h000033330105, 1'b0, 1'b0, 32'h0},        // R5
    '{1'b0, 2'd2, 32'h0A000010, 48'h000011110010, 1'b1, 1'b0, 32'h0}         // R2
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; tick = 1'b0; req_valid = '0; req_ip = '0;
    learn_valid = 1'b0; learn_ip = '0; learn_mac = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    now_cnt = 0;
  endtask

  task automatic do_tick(input int n);
    for (int t = 0; t < n; t++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    now_cnt += n;
  endtask

  task automatic do_learn(input logic [31:0] ip, input logic [47:0] mac);
    int w;
    @(negedge clk);
    learn_valid = 1'b1; learn_ip = ip; learn_mac = mac;
    @(negedge clk);
    learn_valid = 1'b0;
    w = 0;
    while (!learn_ready && w < 200) begin @(negedge clk); w++; end
    if (w >= 200) chk("R10 learn completion", 64'(learn_ready), 64'd1);
  endtask

  task automatic do_lookup(input int r, input logic [31:0] ip, output logic f,
                           output logic [47:0] m, output logic q, output logic [31:0] qip);
    bit ok;
    @(negedge clk);
    req_valid[r] = 1'b1;
    req_ip[r*IW +: IW] = ip;
    ok = 1'b0; f = 1'b0; m = '0; q = 1'b0; qip = '0;
    for (int w = 0; w < 400 && !ok; w++) begin
      @(negedge clk);
      if (rsp_done[r]) begin
        ok = 1'b1; f = rsp_found; m = rsp_mac; q = query_valid; qip = query_ip;
        chk("R9 done goes only to the served client", 64'(rsp_done), 64'(1 << r));
      end
    end
    req_valid[r] = 1'b0;
    if (!ok) chk("R9 lookup done timeout", 64'd0, 64'd1);
    @(negedge clk);
    chk("R9 done is a one-cycle pulse", 64'(rsp_done), 64'd0);
  endtask

  function automatic logic [31:0] kip(input int i);
    return 32'h0A0000A0 + 32'(i);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic f, q;
    logic [47:0] m;
    logic [31:0] qip;
    int order [3];
    int got;

    local_ip = 32'h0A000005; subnet_mask = 32'hFFFFFF00;
    gateway_ip = 32'h0A000001; refresh_period = 8'd200;
    apply_reset();
    chk("R1 no done after reset", 64'(rsp_done), 64'd0);
    chk("R1 no query after reset", 64'(query_valid), 64'd0);
    chk("R1 learn_ready after reset", 64'(learn_ready), 64'd1);

    // vector table: R1 R2 R3 R4 R5
    for (int i = 0; i < 10; i++) begin
      if (VEC[i].is_learn) begin
        do_learn(VEC[i].ip, VEC[i].mac);
      end else begin
        do_lookup(int'(VEC[i].rid), VEC[i].ip, f, m, q, qip);
        chk($sformatf("R2/R3/R4 vector %0d found", i), 64'(f), 64'(VEC[i].exp_found));
        chk($sformatf("R2/R3/R4 vector %0d mac", i), 64'(m), 64'(VEC[i].mac));
        chk($sformatf("R2/R3/R4 vector %0d query", i), 64'(q), 64'(VEC[i].exp_query));
        if (VEC[i].exp_query)
          chk($sformatf("R3/R4 vector %0d query ip", i), 64'(qip), 64'(VEC[i].exp_qip));
      end
    end

    // R5: the dropped remote learn is absent once the mask makes it local
    subnet_mask = 32'h0;
    do_lookup(0, 32'hC0A80105, f, m, q, qip);
    chk("R5 remote learn not stored", 64'(f), 64'd0);
    subnet_mask = 32'hFFFFFF00;

    // R6 R7: fresh table, records K0..K7 with timestamps 0..7
    apply_reset();
    chk("R1 learn_ready after second reset", 64'(learn_ready), 64'd1);
    for (int i = 0; i < 8; i++) begin
      do_learn(kip(i), 48'hAA0000000000 + 48'(i));
      do_tick(1);
    end
    do_learn(kip(3), 48'hBB0000000003);
    do_lookup(0, kip(3), f, m, q, qip);
    chk("R6 rewritten mac", 64'(m), 64'h0000BB0000000003);
    do_lookup(0, kip(0), f, m, q, qip);
    chk("R6 R7 oldest record kept after in-place rewrite", 64'(f), 64'd1);
    do_lookup(0, kip(7), f, m, q, qip);
    chk("R7 empty slots used before eviction", 64'(m), 64'h0000AA0000000007);
    do_tick(1);
    do_learn(kip(8), 48'hAA0000000008);
    do_lookup(0, kip(0), f, m, q, qip);
    chk("R7 largest age evicted first", 64'(f), 64'd0);
    do_lookup(0, kip(8), f, m, q, qip);
    chk("R7 new record present", 64'(m), 64'h0000AA0000000008);
    do_lookup(0, kip(1), f, m, q, qip);
    chk("R7 next oldest still present", 64'(f), 64'd1);
    do_learn(kip(9), 48'hAA0000000009);
    do_lookup(0, kip(1), f, m, q, qip);
    chk("R7 second eviction", 64'(f), 64'd0);
    do_lookup(0, kip(3), f, m, q, qip);
    chk("R7 refreshed record survives", 64'(f), 64'd1);

    // R9: last served was client 0, so order must be 1, 2, 0
    @(negedge clk);
    req_ip = {kip(6), kip(5), kip(4)};
    req_valid = 3'b111;
    got = 0;
    for (int w = 0; w < 400 && got < 3; w++) begin
      @(negedge clk);
      for (int k = 0; k < NR; k++) begin
        if (rsp_done[k] && got < 3) begin
          order[got] = k;
          got++;
          req_valid[k] = 1'b0;
        end
      end
    end
    req_valid = '0;
    chk("R9 served count", 64'(got), 64'd3);
    chk("R9 first grant", 64'(order[0]), 64'd1);
    chk("R9 second grant", 64'(order[1]), 64'd2);
    chk("R9 third grant", 64'(order[2]), 64'd0);

    // R8: staleness boundary and wrap
    refresh_period = 8'd3;
    do_learn(32'h0A0000C0, 48'h0000CC0000C0);
    do_tick(3);
    do_lookup(0, 32'h0A0000C0, f, m, q, qip);
    chk("R8 age equal to period is fresh", 64'(q), 64'd0);
    do_tick(1);
    do_lookup(1, 32'h0A0000C0, f, m, q, qip);
    chk("R8 stale hit found", 64'(f), 64'd1);
    chk("R8 stale hit mac", 64'(m), 64'h0000CC0000C0);
    chk("R8 stale hit queries", 64'(q), 64'd1);
    chk("R8 stale query ip", 64'(qip), 64'h0A0000C0);
    do_tick((254 - now_cnt) & 255);
    do_learn(32'h0A0000D0, 48'h0000DD0000D0);
    do_tick(2);
    do_lookup(2, 32'h0A0000D0, f, m, q, qip);
    chk("R8 wrapped age is fresh", 64'(q), 64'd0);
    chk("R8 wrapped hit found", 64'(f), 64'd1);

    // R10: second learn offered while busy is ignored
    @(negedge clk);
    learn_valid = 1'b1; learn_ip = 32'h0A0000E0; learn_mac = 48'h0000EE0000E0;
    @(negedge clk);
    chk("R10 learn_ready low after accept", 64'(learn_ready), 64'd0);
    learn_ip = 32'h0A0000E1; learn_mac = 48'h0000EE0000E1;
    @(negedge clk);
    learn_valid = 1'b0;
    for (int w = 0; w < 200 && !learn_ready; w++) @(negedge clk);
    do_lookup(0, 32'h0A0000E1, f, m, q, qip);
    chk("R10 learn offered while busy ignored", 64'(f), 64'd0);
    do_lookup(1, 32'h0A0000E0, f, m, q, qip);
    chk("R10 accepted learn stored", 64'(m), 64'h0000EE0000E0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule